// File: doc/BRIEF.md
# Piecewise-ratio external clock divider

This block divides a fixed 96 MHz reference clock to drive an external master or bit clock. The divide ratio is held in a 6-bit ratio code inside a 16-bit control word. The code maps to the divisor in two segments. Below divisor 8 each code step adds one to the divisor. Above 8 each step adds two. As a result, odd divisors of 9 and more cannot be produced.

A combinational helper turns a requested divisor into the nearest legal code, always rounding toward the slower output. A rate-update strobe writes that code into the control word. The same strobe clears the source-select bit, which forces the 96 MHz reference, and leaves every other bit alone. A decoder turns the stored code back into a divisor. The block reports the divisor in use and the resulting output rate in kHz.

A new code waits for the end of the current output period before it takes effect, so the output never shows a runt pulse.

Top module: `ecd_top`

## Requirements
- R1: After reset the control word is 0x0000, the divisor in use is 2, the reported rate is 48000 kHz and the output clock is high.
- R2: Ratio codes 0 through 6 (control bits 7:2) decode to a divisor equal to the code plus 2.
- R3: Ratio codes 7 through 50 decode to a divisor of 8 + 2·(code − 6). Codes 51 through 63 saturate to divisor 96.
- R4: The helper takes the requested divisor and picks the smallest legal divisor that is not below it. A request under 2 gives 2. A request of 96 or more gives 96. An odd request of 9 or more is raised by one.
- R5: The code presented by the helper is the code whose decoded divisor equals the legal divisor chosen in R4.
- R6: A rate update writes the helper code into control bits 7:2 and clears bit 0 (the source select). Bit 1 and bits 15:8 keep their values.
- R7: A register write loads all 16 control bits. If a write and a rate update arrive in the same cycle, the update wins and the write is dropped.
- R8: The output period is exactly the active divisor in reference cycles. The high phase lasts ceil(div/2) cycles and the low phase floor(div/2), so an odd divisor has a high phase one cycle longer than its low phase.
- R9: A changed ratio code becomes the active divisor only at the first output-period boundary after it is stored.
- R10: The reported rate equals 96000 divided by the active divisor, rounded down, in kHz.
- R11: The reported divisor is always the divisor currently in use and always lies in the range 2 to 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 96 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Load the full control word |
| ctrl_wdata_i | input | 16 | Control word to load |
| upd_i | input | 1 | Rate update: store the helper code, clear the source bit |
| req_div_i | input | 7 | Requested divisor fed to the helper |
| code_o | output | 6 | Ratio code computed for req_div_i |
| legal_div_o | output | 7 | Legal divisor chosen for req_div_i |
| ctrl_o | output | 16 | Current control word |
| eff_div_o | output | 7 | Divisor in use |
| rate_khz_o | output | 17 | Output rate in kHz |
| clk_o | output | 1 | Divided clock |

## Verification
The bench targets the fold point of the encoding at divisor 8 and code 6. A decoder that is off by one segment there shifts every divisor above 8 by two.

It sweeps every request from 0 to 127. This catches a helper that rounds odd requests down, which would make the output faster than asked, or one that does not clamp at 2 and 96. It also drives codes 51 to 63, which a decoder without saturation would turn into divisors above 96.

Codes change in the middle of long periods, and a write collides with an update in the same cycle. The cycle-exact model flags any early divisor switch, since that shows up as a shortened period or a runt pulse. It also flags a write that wins over the update, and an update that disturbs bit 1 or the upper byte.

// File: rtl/ecd_pkg.sv
package ecd_pkg;
  localparam int CTRL_W   = 16;
  localparam int CODE_LSB = 2;
  localparam int CODE_W   = 6;
  localparam int SRC_BIT  = 0;
endpackage

// File: rtl/ecd_code_enc.sv
module ecd_code_enc #(
  parameter int DIV_W       = 7,
  parameter int CODE_W      = 6,
  parameter int MIN_DIV     = 2,
  parameter int LIN_MAX_DIV = 8,
  parameter int MAX_DIV     = 96
) (
  input  logic [DIV_W-1:0]  req_div_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int LIN_LAST_CODE = LIN_MAX_DIV - MIN_DIV;

  int r, d, c;

  always_comb begin
    r = int'(req_div_i);
    if (r < MIN_DIV)                          d = MIN_DIV;
    else if (r >= MAX_DIV)                    d = MAX_DIV;
    else if (r > LIN_MAX_DIV && (r % 2) == 1) d = r + 1;  // round toward slower
    else                                      d = r;
    if (d <= LIN_MAX_DIV) c = d - MIN_DIV;
    else                  c = LIN_LAST_CODE + (d - LIN_MAX_DIV) / 2;
    div_o  = DIV_W'(d);
    code_o = CODE_W'(c);
  end
endmodule

// File: rtl/ecd_code_dec.sv
module ecd_code_dec #(
  parameter int DIV_W       = 7,
  parameter int CODE_W      = 6,
  parameter int MIN_DIV     = 2,
  parameter int LIN_MAX_DIV = 8,
  parameter int MAX_DIV     = 96
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DIV_W-1:0]  div_o
);
  localparam int LIN_LAST_CODE = LIN_MAX_DIV - MIN_DIV;
  localparam int MAX_CODE      = LIN_LAST_CODE + (MAX_DIV - LIN_MAX_DIV) / 2;

  int c, d;

  always_comb begin
    c = int'(code_i);
    if (c <= LIN_LAST_CODE) d = c + MIN_DIV;
    else if (c >= MAX_CODE) d = MAX_DIV;
    else                    d = LIN_MAX_DIV + 2 * (c - LIN_LAST_CODE);
    div_o = DIV_W'(d);
  end
endmodule

// File: rtl/ecd_clk_gen.sv
module ecd_clk_gen #(
  parameter int DIV_W   = 7,
  parameter int MIN_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] nxt_div_i,
  output logic [DIV_W-1:0] act_div_o,
  output logic             clk_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d;
  logic [DIV_W:0]   hi_d;
  logic             wrap, clk_q;

  assign wrap = (cnt_q == div_q - DIV_W'(1));

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      div_d = nxt_div_i;  // new ratio only at period boundary
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
      div_d = div_q;
    end
    hi_d = ({1'b0, div_d} + (DIV_W+1)'(1)) >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= DIV_W'(MIN_DIV);
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      clk_q <= ({1'b0, cnt_d} < hi_d);
    end
  end

  assign act_div_o = div_q;
  assign clk_o     = clk_q;

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q);
  p_high_at_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> clk_q);
  p_low_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == div_q - DIV_W'(1)) |-> !clk_q);
  p_div_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q)) |-> ($past(cnt_q) == $past(div_q) - DIV_W'(1)));
endmodule

// File: rtl/ecd_top.sv
module ecd_top #(
  parameter int DIV_W       = 7,
  parameter int MIN_DIV     = 2,
  parameter int LIN_MAX_DIV = 8,
  parameter int MAX_DIV     = 96,
  parameter int REF_KHZ     = 96000,
  parameter int RATE_W      = 17
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ctrl_we_i,
  input  logic [ecd_pkg::CTRL_W-1:0] ctrl_wdata_i,
  input  logic                      upd_i,
  input  logic [DIV_W-1:0]          req_div_i,
  output logic [ecd_pkg::CODE_W-1:0] code_o,
  output logic [DIV_W-1:0]          legal_div_o,
  output logic [ecd_pkg::CTRL_W-1:0] ctrl_o,
  output logic [DIV_W-1:0]          eff_div_o,
  output logic [RATE_W-1:0]         rate_khz_o,
  output logic                      clk_o
);
  import ecd_pkg::*;

  logic [CTRL_W-1:0] ctrl_q, ctrl_upd;
  logic [CODE_W-1:0] enc_code;
  logic [DIV_W-1:0]  enc_div, dec_div, act_div;

  ecd_code_enc #(.DIV_W(DIV_W), .CODE_W(CODE_W), .MIN_DIV(MIN_DIV),
                 .LIN_MAX_DIV(LIN_MAX_DIV), .MAX_DIV(MAX_DIV)) u_enc (
    .req_div_i(req_div_i), .div_o(enc_div), .code_o(enc_code));

  ecd_code_dec #(.DIV_W(DIV_W), .CODE_W(CODE_W), .MIN_DIV(MIN_DIV),
                 .LIN_MAX_DIV(LIN_MAX_DIV), .MAX_DIV(MAX_DIV)) u_dec (
    .code_i(ctrl_q[CODE_LSB +: CODE_W]), .div_o(dec_div));

  ecd_clk_gen #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .nxt_div_i(dec_div),
    .act_div_o(act_div), .clk_o(clk_o));

  always_comb begin
    ctrl_upd = ctrl_q;
    ctrl_upd[CODE_LSB +: CODE_W] = enc_code;
    ctrl_upd[SRC_BIT] = 1'b0;  // force reference source
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (upd_i)     ctrl_q <= ctrl_upd;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end

  assign code_o      = enc_code;
  assign legal_div_o = enc_div;
  assign ctrl_o      = ctrl_q;
  assign eff_div_o   = act_div;
  assign rate_khz_o  = RATE_W'(32'(REF_KHZ) / 32'(act_div));

  p_upd_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (ctrl_q[CTRL_W-1:8] == $past(ctrl_q[CTRL_W-1:8])) &&
              (ctrl_q[1] == $past(ctrl_q[1])) && !ctrl_q[SRC_BIT]);
  p_upd_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ctrl_we_i) |=> (ctrl_q[CODE_LSB +: CODE_W] == $past(enc_code)));
  p_enc_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(enc_div) <= LIN_MAX_DIV) || !enc_div[0]);
  p_enc_slower_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(req_div_i) <= MAX_DIV) |-> (enc_div >= req_div_i));
  p_div_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(act_div) >= MIN_DIV) && (int'(act_div) <= MAX_DIV));
endmodule

// File: tb/ecd_top_bench.sv
module ecd_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic        upd = 1'b0;
  logic [6:0]  req = '0;
  logic [5:0]  code;
  logic [6:0]  ldiv, eff;
  logic [15:0] ctrl;
  logic [16:0] rate;
  logic        dclk;

  int total = 0, bad = 0;
  bit done = 0, live = 0;

  ecd_top u_ecd_top (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .upd_i(upd), .req_div_i(req), .code_o(code), .legal_div_o(ldiv),
    .ctrl_o(ctrl), .eff_div_o(eff), .rate_khz_o(rate), .clk_o(dclk));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_dec(int c);
    if (c <= 6) return c + 2;
    if (c >= 50) return 96;
    return 8 + 2 * (c - 6);
  endfunction

  function automatic int f_legal(int r);
    for (int d = 2; d < 96; d++) begin
      if (d > 8 && (d % 2) == 1) continue;
      if (d >= r) return d;
    end
    return 96;
  endfunction

  function automatic int f_code(int d);
    for (int c = 0; c <= 50; c++) if (f_dec(c) == d) return c;
    return -1;
  endfunction

  task automatic chk(string req_tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  // cycle reference model
  logic [15:0] m_ctrl;
  int m_div, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_div = 2; m_cnt = 0;
    end else begin
      if (m_cnt == m_div - 1) begin
        m_cnt = 0;
        m_div = f_dec(int'(m_ctrl[7:2]));
      end else m_cnt++;
      if (upd)
        m_ctrl = (m_ctrl & 16'hFF02) | 16'(f_code(f_legal(int'(req))) << 2);
      else if (we) m_ctrl = wdata;
    end
  end

  always @(negedge clk) if (live && rst_n) begin
    chk("R8", "clk_o", int'(dclk), (m_cnt < (m_div + 1) / 2) ? 1 : 0);
    chk("R6 R7", "ctrl_o", int'(ctrl), int'(m_ctrl));
    chk("R9 R11", "eff_div_o", int'(eff), m_div);
    chk("R10", "rate_khz_o", int'(rate), 96000 / m_div);
  end

  task automatic do_upd(int r);
    @(negedge clk); req = 7'(r); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic do_wr(logic [15:0] v);
    @(negedge clk); wdata = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ctrl", int'(ctrl), 0);
    chk("R1", "eff_div", int'(eff), 2);
    chk("R1", "rate", int'(rate), 48000);
    chk("R1", "clk_o", int'(dclk), 1);
    rst_n = 1'b1; live = 1;
    repeat (10) @(negedge clk);

    // R4 R5 helper sweep
    for (int r = 0; r < 128; r++) begin
      @(negedge clk); req = 7'(r); #1;
      chk("R4", "legal_div_o", int'(ldiv), f_legal(r));
      chk("R5", "code_o", int'(code), f_code(f_legal(r)));
    end

    // updates across both segments, incl. odd divisor 3 and 7
    do_upd(3);  repeat (20) @(negedge clk);
    do_upd(7);  repeat (30) @(negedge clk);
    do_upd(5);  repeat (30) @(negedge clk);
    do_upd(9);  repeat (40) @(negedge clk);
    do_upd(95); repeat (50) @(negedge clk);  // mid-period change follows (R9)
    do_upd(0);  repeat (200) @(negedge clk);
    do_upd(97); repeat (250) @(negedge clk);

    // R6 bits kept, source cleared
    do_wr(16'hA5FF); repeat (250) @(negedge clk);
    do_upd(12); repeat (3) @(negedge clk);
    chk("R6", "ctrl after update", int'(ctrl), int'(16'hA5FE & 16'hFF03) | (f_code(12) << 2));

    // R7 collision: update wins
    @(negedge clk); wdata = 16'h1234; we = 1'b1; req = 7'd4; upd = 1'b1;
    @(negedge clk); we = 1'b0; upd = 1'b0;
    chk("R7", "ctrl on collision", int'(ctrl), int'(16'hA502) | (2 << 2));
    do_wr(16'h00C4); repeat (3) @(negedge clk);
    chk("R7", "ctrl full write", int'(ctrl), 16'h00C4);

    // R2 R3 decode sweep incl. saturation codes
    for (int c = 0; c < 64; c++) begin
      do_wr(16'(c << 2));
      repeat (200) @(negedge clk);
      chk((c <= 6) ? "R2" : "R3", "decoded divisor", int'(eff), f_dec(c));
    end

    live = 0; done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule